// File: doc/BRIEF.md
# Debug Single-Step Sequencer

This block follows the hardware single-step state of one processor core. A debugger arms stepping by setting a step-enable level. On a qualifying exception return the sequencer is loaded into one of two active states, picked by the saved step bit. After that, each instruction-fetch strobe moves it along. The first fetch marks the instruction as the stepped one. The following fetch raises a one-cycle step-exception pulse and clears the exclusive monitor.

The block does not work out whether debug is enabled. It does not take the exception and it does not track the exception level. The enclosing core supplies these conditions as flags on the exception-return event. The current state is visible as a two-bit code. The register that holds it can be built as a binary register or as a one-hot register, chosen by a parameter.

Top module: `dbg_step_fsm`

## Requirements
- R1: After reset, `state_o` is 2'b00 (idle), and `step_exc_o`, `clr_excl_o` and `stepped_o` are 0.
- R2: In idle, a fetch (`fetch_stb`=1 with `eret_vld`=0) leaves the state idle, raises no step exception and clears `stepped_o`.
- R3: In armed (2'b01), a fetch with `dbg_mask`=1 or `step_en`=0 returns the state to idle and clears `stepped_o`.
- R4: In armed, a fetch with `dbg_mask`=0 and `step_en`=1 sets `stepped_o` and moves the state to pending (2'b10).
- R5: In pending, a fetch pulses `step_exc_o` in the following cycle only when `dbg_mask`=0 and `step_en`=1. Otherwise `step_exc_o` stays 0.
- R6: In pending, any fetch returns the state to idle and pulses `clr_excl_o` in the following cycle.
- R7: An exception return (`eret_vld`=1) loads the state only when all four of these hold: `step_en`=1, `eret_src_dbg_en`=0, `eret_dst_dbg_en`=1 and `eret_tgt32`=0. Otherwise the state is unchanged.
- R8: When it loads, a saved step bit `eret_saved_ss`=0 selects pending (2'b10) and `eret_saved_ss`=1 selects armed (2'b01).
- R9: When an exception return and a fetch arrive in the same cycle, the fetch has no effect: no pulse is raised and `stepped_o` keeps its value.
- R10: In a cycle with neither a fetch nor an exception return, the state holds and both pulse outputs are 0. The state code 2'b11 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_en | input | 1 | Single-step enable level |
| dbg_mask | input | 1 | Debug-mask bit of the current process state |
| fetch_stb | input | 1 | Instruction-fetch strobe |
| eret_vld | input | 1 | Exception-return event |
| eret_saved_ss | input | 1 | Saved step bit carried by the return |
| eret_src_dbg_en | input | 1 | Debug was enabled at the source level |
| eret_dst_dbg_en | input | 1 | Debug is enabled at the destination level |
| eret_tgt32 | input | 1 | Debug target uses the 32-bit execution state |
| state_o | output | 2 | Current state: 00 idle, 01 armed, 10 pending |
| step_exc_o | output | 1 | One-cycle step-exception pulse |
| stepped_o | output | 1 | The last fetch was the stepped instruction |
| clr_excl_o | output | 1 | One-cycle exclusive-monitor clear pulse |

## Verification
The assertions check the following on every cycle. The state code stays legal and the one-hot register keeps a single bit set. The state holds when no event arrives. A failed return gate leaves the state alone. Each exception pulse and each monitor-clear pulse can be traced back to a fetch in pending, and a pulse never lasts two cycles.

The bench scenarios are needed to show that the saved step bit picks the correct active state and that the four gating flags each block a load. They also show the complete armed-pending-idle walk, with its stepped marker and exception timing, and that an exception return wins over a same-cycle fetch.

// File: rtl/dbg_step_pkg.sv
package dbg_step_pkg;

   localparam int STATE_W = 2;

   typedef enum logic [STATE_W-1:0] {
      ST_IDLE  = 2'b00,
      ST_ARMED = 2'b01,
      ST_PEND  = 2'b10
   } step_st_e;

   typedef struct packed {
      logic     exc;
      logic     clr;
      logic     stp_we;
      logic     stp_val;
   } step_act_t;

endpackage

// File: rtl/dbg_step_eret_gate.sv
module dbg_step_eret_gate
   import dbg_step_pkg::*;
(
   input  logic     eret_vld,
   input  logic     step_en,
   input  logic     saved_ss,
   input  logic     src_dbg_en,
   input  logic     dst_dbg_en,
   input  logic     tgt32,
   output logic     load,
   output step_st_e load_st
);
   logic qual;

   always_comb begin
      qual    = step_en & ~src_dbg_en & dst_dbg_en & ~tgt32;
      load    = eret_vld & qual;
      load_st = saved_ss ? ST_ARMED : ST_PEND;
   end
endmodule

// File: rtl/dbg_step_next.sv
module dbg_step_next
   import dbg_step_pkg::*;
(
   input  step_st_e  cur_st,
   input  logic      fetch,
   input  logic      eret_vld,
   input  logic      load,
   input  step_st_e  load_st,
   input  logic      step_en,
   input  logic      dbg_mask,
   output step_st_e  nxt_st,
   output step_act_t act
);
   logic go;

   always_comb begin
      go     = step_en & ~dbg_mask;
      nxt_st = cur_st;
      act    = '0;
      if (eret_vld) begin
         if (load) nxt_st = load_st;
      end else if (fetch) begin
         act.stp_we = 1'b1;
         unique case (cur_st)
            ST_IDLE: begin
               nxt_st = ST_IDLE;
            end
            ST_ARMED: begin
               if (go) begin
                  nxt_st      = ST_PEND;
                  act.stp_val = 1'b1;
               end else begin
                  nxt_st = ST_IDLE;
               end
            end
            ST_PEND: begin
               nxt_st  = ST_IDLE;
               act.clr = 1'b1;
               act.exc = go;
            end
            default: nxt_st = ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dbg_step_state_reg.sv
module dbg_step_state_reg
   import dbg_step_pkg::*;
#(
   parameter int ONEHOT = 0
)(
   input  logic     clk,
   input  logic     rst_n,
   input  step_st_e nxt_st,
   output step_st_e cur_st
);
   localparam int OH_W = 3;

   generate
      if (ONEHOT != 0 && ONEHOT != 1) begin : g_bad
         $error("dbg_step_state_reg: ONEHOT must be 0 or 1");
      end

      if (ONEHOT == 1) begin : g_oh
         logic [OH_W-1:0] oh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) oh_q <= 3'b001;
            else begin
               oh_q    <= '0;
               unique case (nxt_st)
                  ST_ARMED: oh_q[1] <= 1'b1;
                  ST_PEND:  oh_q[2] <= 1'b1;
                  default:  oh_q[0] <= 1'b1;
               endcase
            end
         end
         always_comb begin
            if (oh_q[2])      cur_st = ST_PEND;
            else if (oh_q[1]) cur_st = ST_ARMED;
            else              cur_st = ST_IDLE;
         end
         assert_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(oh_q) == 1);
      end else begin : g_bin
         step_st_e st_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= ST_IDLE;
            else        st_q <= nxt_st;
         end
         assign cur_st = st_q;
      end
   endgenerate
endmodule

// File: rtl/dbg_step_fsm.sv
module dbg_step_fsm
   import dbg_step_pkg::*;
#(
   parameter int ONEHOT = 0
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step_en,
   input  logic       dbg_mask,
   input  logic       fetch_stb,
   input  logic       eret_vld,
   input  logic       eret_saved_ss,
   input  logic       eret_src_dbg_en,
   input  logic       eret_dst_dbg_en,
   input  logic       eret_tgt32,
   output logic [1:0] state_o,
   output logic       step_exc_o,
   output logic       stepped_o,
   output logic       clr_excl_o
);
   step_st_e  cur_st, nxt_st, load_st;
   step_act_t act;
   logic      load;
   logic      exc_q, clr_q, stp_q;

   dbg_step_eret_gate u_gate (
      .eret_vld  (eret_vld),
      .step_en   (step_en),
      .saved_ss  (eret_saved_ss),
      .src_dbg_en(eret_src_dbg_en),
      .dst_dbg_en(eret_dst_dbg_en),
      .tgt32     (eret_tgt32),
      .load      (load),
      .load_st   (load_st)
   );

   dbg_step_next u_next (
      .cur_st  (cur_st),
      .fetch   (fetch_stb),
      .eret_vld(eret_vld),
      .load    (load),
      .load_st (load_st),
      .step_en (step_en),
      .dbg_mask(dbg_mask),
      .nxt_st  (nxt_st),
      .act     (act)
   );

   dbg_step_state_reg #(.ONEHOT(ONEHOT)) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .nxt_st(nxt_st),
      .cur_st(cur_st)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exc_q <= 1'b0;
         clr_q <= 1'b0;
         stp_q <= 1'b0;
      end else begin
         exc_q <= act.exc;
         clr_q <= act.clr;
         if (act.stp_we) stp_q <= act.stp_val;
      end
   end

   assign state_o    = cur_st;
   assign step_exc_o = exc_q;
   assign clr_excl_o = clr_q;
   assign stepped_o  = stp_q;

   // R10: state code legal and held when idle of events
   assert_legal_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
      state_o != 2'b11);
   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!fetch_stb && !eret_vld) |=> $stable(state_o));
   // R5: exception pulse only after a pending-state fetch, one cycle wide
   assert_exc_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_exc_o) |-> ($past(state_o) == 2'b10 && $past(fetch_stb) && !$past(eret_vld)));
   assert_exc_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      step_exc_o |=> !step_exc_o);
   // R6: monitor clear only when leaving pending
   assert_clr_leave_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clr_excl_o) |-> ($past(state_o) == 2'b10 && state_o == 2'b00));
   // R4: stepped marker rises together with entry to pending
   assert_stepped_pend_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stepped_o) |-> state_o == 2'b10);
   // R7: a blocked return leaves the state alone
   assert_eret_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (eret_vld && !(step_en && !eret_src_dbg_en && eret_dst_dbg_en && !eret_tgt32))
      |=> $stable(state_o));
endmodule

// File: tb/dbg_step_fsm_tb.sv
module dbg_step_fsm_tb_top;
   localparam time CLK_PERIOD = 10;
   localparam int  WATCHDOG   = 5000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step_en = 1'b1, dbg_mask = 1'b0, fetch_stb = 1'b0, eret_vld = 1'b0;
   logic eret_saved_ss = 1'b0, eret_src_dbg_en = 1'b0, eret_dst_dbg_en = 1'b1, eret_tgt32 = 1'b0;
   logic [1:0] state_o;
   logic step_exc_o, stepped_o, clr_excl_o;
   int checks = 0, failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dbg_step_fsm dut_i (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .dbg_mask(dbg_mask),
      .fetch_stb(fetch_stb), .eret_vld(eret_vld), .eret_saved_ss(eret_saved_ss),
      .eret_src_dbg_en(eret_src_dbg_en), .eret_dst_dbg_en(eret_dst_dbg_en),
      .eret_tgt32(eret_tgt32), .state_o(state_o), .step_exc_o(step_exc_o),
      .stepped_o(stepped_o), .clr_excl_o(clr_excl_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // one cycle: inputs set at negedge, result sampled at the next negedge
   task automatic cyc(input logic f, input logic e, input logic ss);
      fetch_stb = f; eret_vld = e; eret_saved_ss = ss;
      @(negedge clk);
      fetch_stb = 1'b0; eret_vld = 1'b0;
   endtask

   task automatic load_to(input logic ss);
      step_en = 1'b1; dbg_mask = 1'b0;
      eret_src_dbg_en = 1'b0; eret_dst_dbg_en = 1'b1; eret_tgt32 = 1'b0;
      cyc(1'b0, 1'b1, ss);
   endtask

   task automatic t_reset;
      chk("R1 state", state_o, 0);
      chk("R1 exc", step_exc_o, 0);
      chk("R1 clr", clr_excl_o, 0);
      chk("R1 stepped", stepped_o, 0);
   endtask

   task automatic t_idle_fetch;
      cyc(1'b1, 1'b0, 1'b0);
      chk("R2 state", state_o, 0);
      chk("R2 exc", step_exc_o, 0);
      chk("R2 stepped", stepped_o, 0);
   endtask

   task automatic t_load_select;
      load_to(1'b1); chk("R8 ss=1 armed", state_o, 1);
      load_to(1'b0); chk("R8 ss=0 pend", state_o, 2);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R6 back to idle", state_o, 0);
   endtask

   task automatic t_gate;
      eret_src_dbg_en = 1'b1; cyc(1'b0, 1'b1, 1'b1);
      chk("R7 src enabled blocks", state_o, 0);
      eret_src_dbg_en = 1'b0; eret_dst_dbg_en = 1'b0; cyc(1'b0, 1'b1, 1'b1);
      chk("R7 dst disabled blocks", state_o, 0);
      eret_dst_dbg_en = 1'b1; eret_tgt32 = 1'b1; cyc(1'b0, 1'b1, 1'b1);
      chk("R7 tgt32 blocks", state_o, 0);
      eret_tgt32 = 1'b0; step_en = 1'b0; cyc(1'b0, 1'b1, 1'b1);
      chk("R7 step off blocks", state_o, 0);
      step_en = 1'b1;
      load_to(1'b1);
      eret_src_dbg_en = 1'b1; cyc(1'b0, 1'b1, 1'b0);
      chk("R7 blocked keeps armed", state_o, 1);
      eret_src_dbg_en = 1'b0;
      cyc(1'b1, 1'b0, 1'b0); cyc(1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_full_step;
      load_to(1'b1);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R4 state pend", state_o, 2);
      chk("R4 stepped", stepped_o, 1);
      chk("R4 no exc yet", step_exc_o, 0);
      cyc(1'b1, 1'b0, 1'b0);
      chk("R5 exc pulse", step_exc_o, 1);
      chk("R6 clr pulse", clr_excl_o, 1);
      chk("R6 idle", state_o, 0);
      chk("R2 stepped cleared", stepped_o, 0);
      cyc(1'b0, 1'b0, 1'b0);
      chk("R10 exc drops", step_exc_o, 0);
      chk("R10 clr drops", clr_excl_o, 0);
   endtask

   task automatic t_armed_blocked;
      load_to(1'b1);
      dbg_mask = 1'b1; cyc(1'b1, 1'b0, 1'b0);
      chk("R3 mask idle", state_o, 0);
      chk("R3 mask stepped", stepped_o, 0);
      dbg_mask = 1'b0;
      load_to(1'b1);
      step_en = 1'b0; cyc(1'b1, 1'b0, 1'b0);
      chk("R3 disabled idle", state_o, 0);
      step_en = 1'b1;
   endtask

   task automatic t_pend_masked;
      load_to(1'b0);
      dbg_mask = 1'b1; cyc(1'b1, 1'b0, 1'b0);
      chk("R5 masked no exc", step_exc_o, 0);
      chk("R6 masked clr", clr_excl_o, 1);
      chk("R6 masked idle", state_o, 0);
      dbg_mask = 1'b0;
      load_to(1'b0);
      step_en = 1'b0; cyc(1'b1, 1'b0, 1'b0);
      chk("R5 disabled no exc", step_exc_o, 0);
      step_en = 1'b1;
   endtask

   task automatic t_priority;
      load_to(1'b1);
      cyc(1'b1, 1'b0, 1'b0);            // to pending, stepped=1
      cyc(1'b1, 1'b1, 1'b1);            // return wins, reload armed
      chk("R9 state armed", state_o, 1);
      chk("R9 no exc", step_exc_o, 0);
      chk("R9 no clr", clr_excl_o, 0);
      chk("R9 stepped kept", stepped_o, 1);
      cyc(1'b1, 1'b0, 1'b0); cyc(1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_hold;
      load_to(1'b0);
      repeat (4) cyc(1'b0, 1'b0, 1'b0);
      chk("R10 hold pend", state_o, 2);
      chk("R10 no pulse", step_exc_o, 0);
      cyc(1'b1, 1'b0, 1'b0);
   endtask

   initial begin
      @(negedge clk); @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_idle_fetch;
      t_load_select;
      t_gate;
      t_full_step;
      t_armed_blocked;
      t_pend_masked;
      t_priority;
      t_hold;
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule